// File: doc/BRIEF.md
# Bi-phase Forward Frame Receiver

This block turns a single bi-phase coded serial line into command frames. The line passes through a two-flop synchroniser and a glitch filter. After that, the block times the gap between each pair of filtered edges. It sorts each gap into one half-bit, two half-bits or out of range. From that stream of gap classes it rebuilds the bits of a frame, which has a start bit, sixteen payload bits and then a quiet stop period.

The receiver keeps a running half-bit position inside the frame. From this position it knows whether an edge falls in the middle of a bit or on a bit boundary. Only mid-bit edges carry data, and the direction of the edge gives the bit value. A good frame yields a one-cycle valid pulse with its first byte on the address output and its second byte on the data output. A broken frame yields a one-cycle error pulse and no frame output. After an error the receiver ignores the line for a fixed recovery time, then returns to waiting for a frame.

All timing comes from parameters counted in clock cycles: the half-bit length, the glitch-filter length and the recovery time. The defaults suit 1200 bit/s at a 50 MHz clock.

Top module: `fwd_frame_rx`

## Requirements
- R1: After reset `frm_valid` and `frm_err` are low and `frm_addr` and `frm_data` read 0x00.
- R2: The line idles high. A frame is a start bit of value 1 followed by 16 payload bits, each sent most significant bit first. A 1 is low for the first half-bit and high for the second; a 0 is the reverse. A good frame gives one `frm_valid` pulse, with the first 8 payload bits on `frm_addr` and the last 8 on `frm_data`.
- R3: An edge gap counts as one half-bit when it lies within ±10 % of `HALF_CYC`, and as two half-bits when it lies within ±10 % of twice `HALF_CYC`. Frames whose half-bits are stretched or shrunk by up to 8 % decode correctly.
- R4: An edge gap outside both windows is a violation. The frame produces one `frm_err` pulse and no `frm_valid`.
- R5: A bit with no mid-bit transition is a violation. This shows up as a two-half-bit gap that starts on a bit boundary.
- R6: A frame whose payload has fewer or more than 16 bits is a violation.
- R7: A line held low for longer than the two-half-bit window is a violation.
- R8: `frm_valid` is asserted only once the line has stayed high for at least two bit periods after the end of the last payload bit. A start edge of the next frame that arrives exactly at that limit is accepted as the start of a new frame.
- R9: A pulse shorter than `FILT_LEN` cycles on the line has no effect.
- R10: After an error pulse the line is ignored for `RECOVER_CYC` cycles. A complete frame sent in that window produces no output, and a frame sent after it is decoded.
- R11: `frm_valid` and `frm_err` are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_in | input | 1 | Raw serial line, asynchronous to `clk` |
| frm_valid | output | 1 | One-cycle pulse: a good frame was received |
| frm_addr | output | 8 | First payload byte of the last good frame |
| frm_data | output | 8 | Second payload byte of the last good frame |
| frm_err | output | 1 | One-cycle pulse: a frame was discarded |

## Verification
Two events can fall in the same cycle. The quiet-time limit that completes a frame can be reached in the very cycle in which the falling edge of the next frame's start bit is detected. The bench provokes this by sending frames back to back with exactly two bit periods of idle. It does so once with a frame ending in a 0 (last edge on the bit boundary) and once with a frame ending in a 1 (last edge mid-bit). It judges the result by requiring both frames to come out valid, with the first valid pulse landing within a few cycles of four half-bits after the end of its last bit.

// File: rtl/fwd_rx_pkg.sv
package fwd_rx_pkg;

    // classification of one edge-to-edge gap
    typedef enum logic [1:0] {
        IV_BAD = 2'd0,
        IV_ONE = 2'd1,
        IV_TWO = 2'd2
    } iv_cls_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FRAME = 2'd1,
        ST_BLACK = 2'd2
    } dec_st_e;

    localparam int PAYLOAD_BITS = 16;
    // half-bit index of the final possible edge: boundary after the last payload bit
    localparam int LAST_POS     = 2 * PAYLOAD_BITS + 2;
    localparam int POS_W        = $clog2(LAST_POS + 3);

    // gap counter must reach five half-bits plus one for stop detection
    function automatic int ivl_width(input int half);
        return $clog2(5 * half + 2);
    endfunction

endpackage

// File: rtl/rx_line_cond.sv
module rx_line_cond #(
    parameter int FILT_LEN = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int FW = $clog2(FILT_LEN + 1);

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic          filt;
        logic          prev;
        logic [FW-1:0] fcnt;
    } lc_t;

    lc_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.s1   = line_i;
        r_d.s2   = r_q.s1;
        r_d.prev = r_q.filt;
        if (r_q.s2 != r_q.filt) begin
            if (r_q.fcnt == FW'(FILT_LEN - 1)) begin
                r_d.filt = r_q.s2;
                r_d.fcnt = '0;
            end else begin
                r_d.fcnt = r_q.fcnt + 1'b1;
            end
        end else begin
            r_d.fcnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{s1: 1'b1, s2: 1'b1, filt: 1'b1, prev: 1'b1, fcnt: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign line_o = r_q.filt;
    assign rise_o = r_q.filt & ~r_q.prev;
    assign fall_o = ~r_q.filt & r_q.prev;

    AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rise_o, fall_o})); // R9

    AST_FILT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.filt != $past(r_q.filt)) |-> ($past(r_q.s2) == r_q.filt)); // R9

endmodule

// File: rtl/rx_interval.sv
module rx_interval
    import fwd_rx_pkg::*;
#(
    parameter int HALF_CYC = 20833
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               edge_i,
    output logic [ivl_width(HALF_CYC)-1:0]     cnt_o,
    output iv_cls_e                            cls_o,
    output logic                               long_o
);
    localparam int CW  = ivl_width(HALF_CYC);
    localparam int TOL = HALF_CYC / 10;
    localparam logic [CW-1:0] ONE_LO  = CW'(HALF_CYC - TOL);
    localparam logic [CW-1:0] ONE_HI  = CW'(HALF_CYC + TOL);
    localparam logic [CW-1:0] TWO_LO  = CW'(2 * HALF_CYC - 2 * TOL);
    localparam logic [CW-1:0] TWO_HI  = CW'(2 * HALF_CYC + 2 * TOL);
    localparam logic [CW-1:0] CNT_SAT = CW'(5 * HALF_CYC + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } iv_t;

    iv_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (edge_i) begin
            r_d.cnt = CW'(1);
        end else if (r_q.cnt != CNT_SAT) begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{cnt: '0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        if (r_q.cnt >= ONE_LO && r_q.cnt <= ONE_HI) begin
            cls_o = IV_ONE;
        end else if (r_q.cnt >= TWO_LO && r_q.cnt <= TWO_HI) begin
            cls_o = IV_TWO;
        end else begin
            cls_o = IV_BAD;
        end
    end

    assign cnt_o  = r_q.cnt;
    assign long_o = r_q.cnt > TWO_HI;

    AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        edge_i |=> (cnt_o == CW'(1))); // R4

endmodule

// File: rtl/rx_frame_dec.sv
module rx_frame_dec
    import fwd_rx_pkg::*;
#(
    parameter int HALF_CYC    = 20833,
    parameter int RECOVER_CYC = 85000
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           line_i,
    input  logic                           rise_i,
    input  logic                           fall_i,
    input  logic [ivl_width(HALF_CYC)-1:0] cnt_i,
    input  iv_cls_e                        cls_i,
    input  logic                           long_i,
    output logic                           valid_o,
    output logic                           err_o,
    output logic [7:0]                     addr_o,
    output logic [7:0]                     data_o
);
    localparam int CW = ivl_width(HALF_CYC);
    localparam int BW = $clog2(RECOVER_CYC + 1);
    localparam logic [CW-1:0]      STOP_ODD  = CW'(5 * HALF_CYC);
    localparam logic [CW-1:0]      STOP_EVEN = CW'(4 * HALF_CYC);
    localparam logic [POS_W-1:0]   POS_END   = POS_W'(LAST_POS);
    localparam logic [POS_W-1:0]   POS_MID   = POS_W'(LAST_POS - 1);
    localparam logic [BW-1:0]      BLK_LAST  = BW'(RECOVER_CYC - 1);

    typedef struct packed {
        dec_st_e                       st;
        logic [POS_W-1:0]              pos;
        logic [2*8-1:0]                sh;
        logic [BW-1:0]                 btmr;
        logic                          valid;
        logic                          err;
        logic [7:0]                    addr;
        logic [7:0]                    data;
    } dec_t;

    dec_t r_d, r_q;

    logic [POS_W:0] np;
    logic           bad;
    logic           at_end;
    logic           stop_ok;

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;
        r_d.err   = 1'b0;
        np        = '0;
        bad       = 1'b0;
        at_end    = (r_q.pos == POS_MID) || (r_q.pos == POS_END);
        stop_ok   = cnt_i >= (r_q.pos[0] ? STOP_ODD : STOP_EVEN);

        unique case (r_q.st)
            ST_IDLE: begin
                if (fall_i) begin
                    r_d.st  = ST_FRAME;
                    r_d.pos = '0;
                    r_d.sh  = '0;
                end
            end

            ST_FRAME: begin
                if (fall_i && at_end && stop_ok) begin
                    // previous frame complete, this edge opens the next one
                    r_d.valid = 1'b1;
                    r_d.addr  = r_q.sh[15:8];
                    r_d.data  = r_q.sh[7:0];
                    r_d.pos   = '0;
                    r_d.sh    = '0;
                end else if (rise_i || fall_i) begin
                    unique case (cls_i)
                        IV_ONE:  np = {1'b0, r_q.pos} + 1'b1;
                        IV_TWO: begin
                            np = {1'b0, r_q.pos} + 2'd2;
                            // two half-bits from a boundary skips a mid-bit edge
                            if (!r_q.pos[0]) bad = 1'b1;
                        end
                        default: bad = 1'b1;
                    endcase
                    if (np > {1'b0, POS_END}) bad = 1'b1;
                    if (bad) begin
                        r_d.err  = 1'b1;
                        r_d.st   = ST_BLACK;
                        r_d.btmr = '0;
                    end else begin
                        r_d.pos = np[POS_W-1:0];
                        if (np[0] && np >= (POS_W+1)'(3)) begin
                            r_d.sh = {r_q.sh[14:0], rise_i};
                        end
                    end
                end else if (long_i) begin
                    if (!line_i || !at_end) begin
                        r_d.err  = 1'b1;
                        r_d.st   = ST_BLACK;
                        r_d.btmr = '0;
                    end else if (stop_ok) begin
                        r_d.valid = 1'b1;
                        r_d.addr  = r_q.sh[15:8];
                        r_d.data  = r_q.sh[7:0];
                        r_d.st    = ST_IDLE;
                    end
                end
            end

            ST_BLACK: begin
                if (r_q.btmr >= BLK_LAST) begin
                    r_d.st   = ST_IDLE;
                    r_d.btmr = '0;
                end else begin
                    r_d.btmr = r_q.btmr + 1'b1;
                end
            end

            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, pos: '0, sh: '0, btmr: '0, valid: 1'b0,
                     err: 1'b0, addr: '0, data: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign valid_o = r_q.valid;
    assign err_o   = r_q.err;
    assign addr_o  = r_q.addr;
    assign data_o  = r_q.data;

    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_o && err_o)); // R11

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o); // R11

    AST_ERR_BLACKOUT: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (r_q.st == ST_BLACK)); // R10

    AST_BLACK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.st == ST_BLACK) && ($past(r_q.st) == ST_BLACK)) |-> (!valid_o && !err_o)); // R10

    AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_FRAME) |-> (r_q.pos <= POS_END)); // R6

endmodule

// File: rtl/fwd_frame_rx.sv
module fwd_frame_rx
    import fwd_rx_pkg::*;
#(
    parameter int HALF_CYC    = 20833,
    parameter int FILT_LEN    = 32,
    parameter int RECOVER_CYC = 85000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_in,
    output logic       frm_valid,
    output logic [7:0] frm_addr,
    output logic [7:0] frm_data,
    output logic       frm_err
);
    localparam int CW = ivl_width(HALF_CYC);

    logic          line_f;
    logic          rise;
    logic          fall;
    logic [CW-1:0] gap_cnt;
    iv_cls_e       gap_cls;
    logic          gap_long;

    rx_line_cond #(.FILT_LEN(FILT_LEN)) u_cond (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (line_in),
        .line_o (line_f),
        .rise_o (rise),
        .fall_o (fall)
    );

    rx_interval #(.HALF_CYC(HALF_CYC)) u_ivl (
        .clk    (clk),
        .rst_n  (rst_n),
        .edge_i (rise | fall),
        .cnt_o  (gap_cnt),
        .cls_o  (gap_cls),
        .long_o (gap_long)
    );

    rx_frame_dec #(.HALF_CYC(HALF_CYC), .RECOVER_CYC(RECOVER_CYC)) u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_i  (line_f),
        .rise_i  (rise),
        .fall_i  (fall),
        .cnt_i   (gap_cnt),
        .cls_i   (gap_cls),
        .long_i  (gap_long),
        .valid_o (frm_valid),
        .err_o   (frm_err),
        .addr_o  (frm_addr),
        .data_o  (frm_data)
    );

endmodule

// File: tb/test_fwd_frame_rx.sv
module test_fwd_frame_rx;

    localparam int HALF = 50;
    localparam int FILT = 4;
    localparam int REC  = 2500;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_in = 1'b1;
    logic       frm_valid;
    logic [7:0] frm_addr;
    logic [7:0] frm_data;
    logic       frm_err;

    always #10 clk = ~clk;   // 50 MHz

    fwd_frame_rx #(.HALF_CYC(HALF), .FILT_LEN(FILT), .RECOVER_CYC(REC)) i_fwd_frame_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_in   (line_in),
        .frm_valid (frm_valid),
        .frm_addr  (frm_addr),
        .frm_data  (frm_data),
        .frm_err   (frm_err)
    );

    typedef struct {
        bit         is_err;
        logic [7:0] a;
        logic [7:0] d;
        bit         chk_t;
        string      req;
    } exp_t;

    exp_t   q[$];
    int     n_checks = 0;
    int     n_errors = 0;
    int     n_out    = 0;
    longint cyc      = 0;
    longint last_end = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // monitor: pop and compare each output event
    always @(negedge clk) begin
        exp_t e;
        if (rst_n && (frm_valid || frm_err)) begin
            n_out++;
            check(!(frm_valid && frm_err), "R11", "valid and err together", 1, 0);
            if (q.size() == 0) begin
                check(0, "R4", "unexpected output event (valid,err)", {frm_valid, frm_err}, 0);
            end else begin
                e = q.pop_front();
                if (e.is_err) begin
                    check(frm_err && !frm_valid, e.req, "error pulse expected (valid,err)",
                          {frm_valid, frm_err}, 2'b01);
                end else begin
                    check(frm_valid && !frm_err, e.req, "valid pulse expected (valid,err)",
                          {frm_valid, frm_err}, 2'b10);
                    check(frm_addr == e.a, e.req, "address byte", frm_addr, e.a);
                    check(frm_data == e.d, e.req, "data byte", frm_data, e.d);
                    if (e.chk_t) begin
                        check((cyc - last_end) >= 4*HALF && (cyc - last_end) <= 4*HALF + 20,
                              "R8", "cycles from last bit end to valid", cyc - last_end, 4*HALF);
                    end
                end
            end
        end
    end

    task automatic half_bit(input bit lvl, input int len);
        line_in = lvl;
        repeat (len) @(negedge clk);
    endtask

    // 1 = low then high
    task automatic put_bit(input bit b, input int len);
        half_bit(!b, len);
        half_bit(b, len);
    endtask

    task automatic send_bits(input logic [16:0] bits, input int nb, input int len);
        put_bit(1'b1, len);
        for (int i = 0; i < nb; i++) put_bit(bits[16-i], len);
        line_in  = 1'b1;
        last_end = cyc;
    endtask

    task automatic send_frame(input logic [7:0] a, input logic [7:0] d, input int len,
                              input int idle, input bit chk_t, input string req);
        exp_t e;
        e.is_err = 0; e.a = a; e.d = d; e.chk_t = chk_t; e.req = req;
        q.push_back(e);
        send_bits({a, d, 1'b0}, 16, len);
        repeat (idle) @(negedge clk);
    endtask

    task automatic expect_err(input string req);
        exp_t e;
        e.is_err = 1; e.a = 0; e.d = 0; e.chk_t = 0; e.req = req;
        q.push_back(e);
    endtask

    task automatic settle();
        line_in = 1'b1;
        repeat (REC + 300) @(negedge clk);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog R2 actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        int snap;
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(frm_valid == 0 && frm_err == 0, "R1", "pulses after reset", {frm_valid, frm_err}, 0);
        check(frm_addr == 0 && frm_data == 0, "R1", "bytes after reset", {frm_addr, frm_data}, 0);
        repeat (20) @(negedge clk);

        // R2: plain frames, several bit patterns
        send_frame(8'hA5, 8'h3C, HALF, 6*HALF, 1, "R2");
        send_frame(8'h00, 8'hFF, HALF, 6*HALF, 1, "R2");
        send_frame(8'hFF, 8'h00, HALF, 6*HALF, 1, "R2");
        send_frame(8'h01, 8'h80, HALF, 6*HALF, 1, "R2");

        // R3: stretched and shrunk half-bits inside the windows
        send_frame(8'h5A, 8'hC6, 54, 6*HALF, 0, "R3");
        send_frame(8'hC3, 8'h12, 46, 6*HALF, 0, "R3");

        // R8: back to back with exactly two bit periods idle
        send_frame(8'h12, 8'h34, HALF, 4*HALF, 1, "R8");
        send_frame(8'h56, 8'h79, HALF, 4*HALF, 1, "R8");
        send_frame(8'h9A, 8'hBC, HALF, 6*HALF, 1, "R8");

        // R9: short glitch in idle is ignored
        snap = n_out;
        line_in = 1'b0;
        repeat (2) @(negedge clk);
        line_in = 1'b1;
        repeat (8*HALF) @(negedge clk);
        check(n_out == snap, "R9", "events after glitch", n_out - snap, 0);
        send_frame(8'hE7, 8'h18, HALF, 6*HALF, 1, "R9");

        // R4: gap between the windows
        expect_err("R4");
        half_bit(1'b0, HALF); half_bit(1'b1, 75); half_bit(1'b0, HALF);
        settle();
        // R4: every half-bit 14 % long
        expect_err("R4");
        send_bits({8'h33, 8'h44, 1'b0}, 16, 57);
        settle();

        // R5: bit with no mid-bit transition
        expect_err("R5");
        half_bit(1'b0, HALF); half_bit(1'b1, HALF); half_bit(1'b0, 2*HALF); half_bit(1'b1, HALF);
        settle();

        // R6: 15 and 17 payload bits
        expect_err("R6");
        send_bits({8'h6B, 8'h2D, 1'b0}, 15, HALF);
        settle();
        expect_err("R6");
        send_bits({8'h6B, 8'h2D, 1'b1}, 17, HALF);
        settle();

        // R7: line stuck low
        expect_err("R7");
        half_bit(1'b0, 6*HALF);
        settle();

        // R10: frame inside the blackout is ignored, later frame decodes
        expect_err("R10");
        line_in = 1'b0;
        while (q.size() != 0) @(negedge clk);
        line_in = 1'b1;
        repeat (20) @(negedge clk);
        snap = n_out;
        send_bits({8'h77, 8'h88, 1'b0}, 16, HALF);
        repeat (6*HALF) @(negedge clk);
        check(n_out == snap, "R10", "events during blackout", n_out - snap, 0);
        repeat (600) @(negedge clk);
        send_frame(8'h3C, 8'hA5, HALF, 6*HALF, 1, "R10");

        repeat (8*HALF) @(negedge clk);
        check(q.size() == 0, "R2", "expected events still pending", q.size(), 0);
        summary();
        $finish;
    end

endmodule